// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits between a set of peripherals and one processor. Each peripheral raises its own request line. The block merges them into a single interrupt line toward the processor. When the processor acknowledges, the block picks exactly one requester by fixed priority, where a lower index wins. It answers that peripheral on its own acknowledge line and drives that peripheral's vector onto the vector bus, so the processor can jump to the matching service routine.

The selection is made once, at the clock edge where the processor's acknowledge is first seen high. It then stays frozen for the rest of the acknowledge pulse. The processor ends the exchange by dropping its acknowledge. The grant and the vector drive are released at the next clock edge. Every peripheral's vector is supplied on a flat configuration input. The granted entry is copied into a register at grant time.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `cpu_int` is high in the same cycle that any bit of `irq_req` is high, and low when all bits are low.
- R2: A grant starts only at a clock edge where `cpu_inta` is sampled 1, it was sampled 0 at the previous edge, and some `irq_req` bit is 1. If no request is present at that edge, that acknowledge pulse grants nothing, even if requests arrive later in the pulse.
- R3: `irq_ack` is one-hot during a grant. It selects the lowest-indexed bit of `irq_req` sampled at the grant edge.
- R4: During a grant, `vec_oe` is 1 and `vec_bus` equals `vec_table[k*VEC_W +: VEC_W]`, where k is the granted index. Outside a grant, `vec_oe` is 0 and `vec_bus` is 0.
- R5: While `cpu_inta` stays high, `irq_ack` and `vec_bus` hold their values, even if a higher-priority request arrives or the requests change.
- R6: `irq_ack`, `vec_oe` and `vec_bus` return to 0 at the first clock edge at which `cpu_inta` is sampled 0.
- R7: Requests still pending after a handshake keep `cpu_int` high. The next acknowledge pulse grants the highest-priority remaining requester.
- R8: After reset, `irq_ack`, `vec_oe` and `vec_bus` are 0.
- R9: Changing `vec_table` during a grant does not change `vec_bus`, because the vector is captured at the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req | input | N_PERIPH | Per-peripheral interrupt request; bit 0 has the highest priority |
| vec_table | input | N_PERIPH*VEC_W | Vector of peripheral k in bits k*VEC_W +: VEC_W |
| cpu_inta | input | 1 | Processor interrupt acknowledge; its falling edge ends the handshake |
| cpu_int | output | 1 | Interrupt request to the processor |
| irq_ack | output | N_PERIPH | Per-peripheral acknowledge, one-hot during a grant |
| vec_oe | output | 1 | High while the vector bus carries a granted vector |
| vec_bus | output | VEC_W | Vector of the granted peripheral |

## Verification
`cpu_int` is combinational, so the bench checks it one time step after it changes `irq_req`, within the same cycle. A grant, the vector it drives and its release each take effect at the first rising edge that samples the new level of `cpu_inta`. The bench drives every input on a falling edge and samples the results on the following falling edge, which is half a cycle after the edge that changes them. Hold behaviour is checked over several cycles while requests and the table change under a held acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic {
    HS_IDLE  = 1'b0,
    HS_GRANT = 1'b1
  } hs_state_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_PERIPH = 4,
  localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic [N_PERIPH-1:0] req,
  output logic [N_PERIPH-1:0] pick_oh,
  output logic [IDX_W-1:0]    pick_idx,
  output logic                any_req
);

  // Scan from the lowest priority upward so the lowest index wins.
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = N_PERIPH - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick_oh     = '0;
        pick_oh[i]  = 1'b1;
        pick_idx    = IDX_W'(i);
      end
    end
  end

  assign any_req = |req;

endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
  parameter int N_PERIPH = 4,
  parameter int VEC_W    = 8,
  localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic [N_PERIPH*VEC_W-1:0] table_flat,
  input  logic [IDX_W-1:0]          sel,
  output logic [VEC_W-1:0]          vec_out
);

  always_comb begin
    vec_out = '0;
    for (int i = 0; i < N_PERIPH; i++) begin
      if (sel == IDX_W'(i)) vec_out = table_flat[i*VEC_W +: VEC_W];
    end
  end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_PERIPH = 4,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PERIPH-1:0]       irq_req,
  input  logic [N_PERIPH*VEC_W-1:0] vec_table,
  input  logic                      cpu_inta,
  output logic                      cpu_int,
  output logic [N_PERIPH-1:0]       irq_ack,
  output logic                      vec_oe,
  output logic [VEC_W-1:0]          vec_bus
);

  localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Priority selection and vector lookup.
  logic [N_PERIPH-1:0] pick_oh;
  logic [IDX_W-1:0]    pick_idx;
  logic                any_req;
  logic [VEC_W-1:0]    pick_vec;

  irq_prio_pick #(.N_PERIPH(N_PERIPH)) u_pick (
    .req      (irq_req),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .any_req  (any_req)
  );

  irq_vec_mux #(.N_PERIPH(N_PERIPH), .VEC_W(VEC_W)) u_mux (
    .table_flat (vec_table),
    .sel        (pick_idx),
    .vec_out    (pick_vec)
  );

  assign cpu_int = any_req;

  // Handshake state.
  hs_state_t           state_q, state_d;
  logic                inta_q;
  logic                inta_rise;
  logic                grant_load;
  logic [N_PERIPH-1:0] grant_q;
  logic [VEC_W-1:0]    vec_q;

  assign inta_rise = cpu_inta & ~inta_q;

  always_comb begin
    state_d    = state_q;
    grant_load = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (inta_rise && any_req) begin
          state_d    = HS_GRANT;
          grant_load = 1'b1;
        end
      end
      HS_GRANT: begin
        if (!cpu_inta) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= HS_IDLE;
      inta_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      inta_q  <= cpu_inta;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      grant_q <= '0;
      vec_q   <= '0;
    end else if (grant_load) begin
      grant_q <= pick_oh;
      vec_q   <= pick_vec;
    end
  end

  assign vec_oe  = (state_q == HS_GRANT);
  assign irq_ack = vec_oe ? grant_q : '0;
  assign vec_bus = vec_oe ? vec_q   : '0;

  // Assertions.
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(irq_ack)); // R3

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(vec_oe) |-> ($past(cpu_inta) && ($past(irq_req) != '0))); // R2

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_oe && cpu_inta) |=> ($stable(irq_ack) && $stable(vec_bus))); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_oe && !cpu_inta) |=> (irq_ack == '0 && !vec_oe)); // R6

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_ack == '0) |-> (vec_bus == '0)); // R4

endmodule

// File: tb/irq_vec_arbiter_test.sv
module irq_vec_arbiter_test;

  localparam int N  = 4;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req;
  logic [N*VW-1:0] vec_table;
  logic          cpu_inta;
  logic          cpu_int;
  logic [N-1:0]  irq_ack;
  logic          vec_oe;
  logic [VW-1:0] vec_bus;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_arbiter #(.N_PERIPH(N), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_table(vec_table),
    .cpu_inta(cpu_inta), .cpu_int(cpu_int), .irq_ack(irq_ack),
    .vec_oe(vec_oe), .vec_bus(vec_bus)
  );

  function automatic logic [VW-1:0] vec_of(int k);
    return VW'(8'h10 * (k + 1) + 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_table();
    for (int k = 0; k < N; k++) vec_table[k*VW +: VW] = vec_of(k);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_req = '0; cpu_inta = 1'b0; load_table();
    repeat (3) @(negedge clk);
    chk("R8 ack after reset", 32'(irq_ack), 0);
    chk("R8 oe after reset", 32'(vec_oe), 0);
    chk("R8 bus after reset", 32'(vec_bus), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_int_line();
    irq_req = 4'b0100; #1;
    chk("R1 int with one request", 32'(cpu_int), 1);
    irq_req = 4'b0000; #1;
    chk("R1 int with no request", 32'(cpu_int), 0);
    @(negedge clk);
  endtask

  task automatic t_single();
    irq_req = 4'b0100;
    @(negedge clk); cpu_inta = 1'b1;
    @(negedge clk);
    chk("R3 single grant ack", 32'(irq_ack), 32'h4);
    chk("R4 single grant oe", 32'(vec_oe), 1);
    chk("R4 single grant vector", 32'(vec_bus), 32'(vec_of(2)));
    irq_req = 4'b0000;
    vec_table[2*VW +: VW] = 8'hEE;
    @(negedge clk);
    chk("R9 vector kept after table change", 32'(vec_bus), 32'(vec_of(2)));
    chk("R1 int low after peripheral drop", 32'(cpu_int), 0);
    cpu_inta = 1'b0;
    @(negedge clk);
    chk("R6 ack released", 32'(irq_ack), 0);
    chk("R6 oe released", 32'(vec_oe), 0);
    chk("R6 bus cleared", 32'(vec_bus), 0);
    load_table();
    @(negedge clk);
  endtask

  task automatic t_priority();
    irq_req = 4'b1010;
    @(negedge clk); cpu_inta = 1'b1;
    @(negedge clk);
    chk("R3 lowest index wins", 32'(irq_ack), 32'h2);
    chk("R4 vector of winner", 32'(vec_bus), 32'(vec_of(1)));
    irq_req = 4'b1011;
    repeat (2) @(negedge clk);
    chk("R5 grant held over new higher request", 32'(irq_ack), 32'h2);
    chk("R5 vector held", 32'(vec_bus), 32'(vec_of(1)));
    irq_req = 4'b1001;
    cpu_inta = 1'b0;
    @(negedge clk);
    chk("R6 release after handshake", 32'(irq_ack), 0);
    chk("R7 int stays with pending", 32'(cpu_int), 1);
    cpu_inta = 1'b1;
    @(negedge clk);
    chk("R7 next pulse grants next", 32'(irq_ack), 32'h1);
    chk("R7 next vector", 32'(vec_bus), 32'(vec_of(0)));
    irq_req = 4'b1000; cpu_inta = 1'b0;
    @(negedge clk);
    cpu_inta = 1'b1;
    @(negedge clk);
    chk("R3 last requester granted", 32'(irq_ack), 32'h8);
    chk("R4 last vector", 32'(vec_bus), 32'(vec_of(3)));
    irq_req = 4'b0000; cpu_inta = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_no_request();
    irq_req = 4'b0000;
    cpu_inta = 1'b1;
    @(negedge clk);
    chk("R2 no grant without request", 32'(irq_ack), 0);
    irq_req = 4'b0010;
    repeat (2) @(negedge clk);
    chk("R2 no grant mid pulse", 32'(irq_ack), 0);
    chk("R2 oe low mid pulse", 32'(vec_oe), 0);
    cpu_inta = 1'b0;
    @(negedge clk);
    cpu_inta = 1'b1;
    @(negedge clk);
    chk("R2 grant on fresh rising edge", 32'(irq_ack), 32'h2);
    irq_req = 4'b0000; cpu_inta = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_int_line();
    t_single();
    t_priority();
    t_no_request();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule